// File: doc/BRIEF.md
# Zero-Substitution Line Encoder

This block turns a clocked unipolar data stream into a pair of rail indicators, one for a positive line pulse and one for a negative line pulse, with one output symbol per clock. Ones are sent as pulses of alternating polarity. A mode input chooses the run length that gets replaced: three zeros (B3ZS) or four zeros (HDB3). A short look-ahead window holds the newest bits. When the window fills with a zero run, the run is rewritten into a substitution code that ends in a polarity violation. The code is picked from the parity of rule-following pulses sent since the last violation, so violations always alternate in polarity.

Input rails are sampled on the falling clock edge, and all other state moves on the rising edge. Three controls override the encoder. The remote-loop input sends the receive-side rails to the line instead of the transmit rails. The all-ones request sends a continuous alternating pulse train. The encoder-off input passes already-coded transmit rails straight through. The controls are meant to be held static, and a reset is applied when the mode changes.

Top module: `zsub_line_encoder`

## Requirements
- R1: `mode_b3` high selects a zero-run length of 3 (B3ZS). Low selects a run length of 4 (HDB3).
- R2: Each run of consecutive zeros of the selected length is replaced as it is seen, scanning from the oldest bit. The replacement is B0V or B00V when the count of one-pulses and B pulses since the last V is even. It is 00V or 000V when that count is odd. A V clears the count, and the count is even after reset.
- R3: A data one and a B pulse take the polarity opposite to the previous pulse. A V pulse repeats the polarity of the previous pulse. After reset the previous pulse counts as negative, so the first pulse is positive. In encoder mode at most one rail is high.
- R4: In encoder mode, once a pulse has been sent, the line never shows more zero symbols in a row than the run length minus one.
- R5: The encoder treats a bit as a one when either transmit rail is high. A one on the negative rail alone is therefore encoded exactly like a one on both rails.
- R6: With the encoder on, a bit sampled at a falling edge reaches the line outputs at the (run length + 2)th following rising edge. That is 4.5 clock cycles in B3ZS mode and 5.5 cycles in HDB3 mode.
- R7: With `enc_off` high, and neither override active, both transmit rails pass to the line unchanged and independently. They appear at the second rising edge after sampling.
- R8: With `all_ones` high and `rloop` low, the line carries one pulse every cycle and ignores the transmit rails and `enc_off`. The pulse is positive after odd-numbered rising edges counted from reset release, and negative after even-numbered ones.
- R9: With `rloop` high, the receive rails are sent to the line with the same two-edge latency as R7. Transmit data and `all_ones` have no effect.
- R10: While reset is asserted, both line outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rails sampled on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_b3 | input | 1 | 1 = three-zero substitution, 0 = four-zero substitution |
| enc_off | input | 1 | Pass transmit rails through without substitution |
| all_ones | input | 1 | Send continuous alternating pulses |
| rloop | input | 1 | Send receive rails to the line |
| tx_pos | input | 1 | Transmit positive rail / binary data |
| tx_neg | input | 1 | Transmit negative rail / binary data |
| rx_pos | input | 1 | Receive positive rail for loopback |
| rx_neg | input | 1 | Receive negative rail for loopback |
| line_pos | output | 1 | Positive pulse indicator to the line |
| line_neg | output | 1 | Negative pulse indicator to the line |

## Verification
Several properties are checked on every cycle: the one-hot rail rule in encoder mode, the bound on consecutive empty symbols, the alternation of the all-ones train, and the two-edge pass-through of both bypass paths. The choice between B-led and all-zero codes, the polarity of each V, and the exact mode-dependent latency can only be shown by the bench. It compares long biased-random streams against a sequential reference encoder in both modes, with binary and single-rail input.

// File: rtl/zsub_pkg.sv
package zsub_pkg;
    // Contents of one look-ahead slot
    typedef enum logic [2:0] {
        SL_ZERO = 3'd0,   // data zero, still eligible for substitution
        SL_ONE  = 3'd1,   // data one
        SL_BPLS = 3'd2,   // inserted rule-following pulse
        SL_VPLS = 3'd3,   // inserted violation pulse
        SL_HOLD = 3'd4    // zero already claimed by a substitution
    } slot_e;
endpackage

// File: rtl/zsub_capture.sv
module zsub_capture (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] tx_rails,
    input  logic [1:0] rx_rails,
    output logic [1:0] cap_tx,
    output logic [1:0] cap_rx,
    output logic       din
);
    typedef struct packed {
        logic [1:0] tx;
        logic [1:0] rx;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.tx = tx_rails;
        cap_d.rx = rx_rails;
    end

    // Rails are taken on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign cap_tx = cap_q.tx;
    assign cap_rx = cap_q.rx;
    assign din    = |cap_q.tx;
endmodule

// File: rtl/zsub_subst.sv
module zsub_subst
    import zsub_pkg::*;
#(
    parameter int RUN_A = 3,
    parameter int RUN_B = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_b3,
    input  logic       din,
    output logic [1:0] enc_sym
);
    localparam int WIN = (RUN_A > RUN_B) ? RUN_A : RUN_B;
    localparam int IW  = (WIN > 1) ? $clog2(WIN) : 1;

    typedef struct packed {
        slot_e [WIN-1:0] win;
        logic            lastpos;  // polarity of the latest pulse sent
        logic            par;      // odd count of non-violation pulses
        logic [1:0]      sym;      // {pos, neg}
    } st_t;

    st_t     st_d, st_q;
    logic [IW-1:0] tap;
    slot_e   leave;
    logic    allz;
    int      run;

    always_comb begin
        st_d   = st_q;
        run    = mode_b3 ? RUN_A : RUN_B;
        tap    = mode_b3 ? IW'(RUN_A - 1) : IW'(RUN_B - 1);
        leave  = st_q.win[tap];
        st_d.sym = 2'b00;

        // Emit the oldest slot of the active window
        case (leave)
            SL_ONE, SL_BPLS: begin
                st_d.lastpos = !st_q.lastpos;
                st_d.sym     = st_q.lastpos ? 2'b01 : 2'b10;
                st_d.par     = !st_q.par;
            end
            SL_VPLS: begin
                st_d.sym = st_q.lastpos ? 2'b10 : 2'b01;
                st_d.par = 1'b0;
            end
            default: ;
        endcase

        // Shift the new bit in
        st_d.win[0] = din ? SL_ONE : SL_ZERO;
        for (int i = 1; i < WIN; i++) begin
            st_d.win[i] = st_q.win[i-1];
        end

        // Full run of free zeros: rewrite it into a code
        allz = 1'b1;
        for (int i = 0; i < WIN; i++) begin
            if (i < run && st_d.win[i] != SL_ZERO) allz = 1'b0;
        end
        if (allz) begin
            for (int i = 0; i < WIN; i++) begin
                if (i < run) st_d.win[i] = SL_HOLD;
            end
            st_d.win[0] = SL_VPLS;
            if (!st_d.par) st_d.win[tap] = SL_BPLS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN; i++) st_q.win[i] <= SL_HOLD;
            st_q.lastpos <= 1'b0;
            st_q.par     <= 1'b0;
            st_q.sym     <= 2'b00;
        end else begin
            st_q <= st_d;
        end
    end

    assign enc_sym = st_q.sym;
endmodule

// File: rtl/zsub_outsel.sv
module zsub_outsel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rloop,
    input  logic       all_ones,
    input  logic       enc_off,
    input  logic [1:0] cap_tx,
    input  logic [1:0] cap_rx,
    input  logic [1:0] enc_sym,
    output logic [1:0] line
);
    typedef struct packed {
        logic [1:0] byp;   // pass-through stage
        logic       tog;   // all-ones phase
        logic [1:0] line;
    } os_t;

    os_t os_d, os_q;

    always_comb begin
        os_d     = os_q;
        os_d.byp = rloop ? cap_rx : cap_tx;
        os_d.tog = !os_q.tog;
        // Priority: loopback, then all-ones, then bypass, then encoder
        if (rloop)              os_d.line = os_q.byp;
        else if (all_ones)      os_d.line = os_q.tog ? 2'b01 : 2'b10;
        else if (enc_off)       os_d.line = os_q.byp;
        else                    os_d.line = enc_sym;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) os_q <= '0;
        else        os_q <= os_d;
    end

    assign line = os_q.line;
endmodule

// File: rtl/zsub_line_encoder.sv
module zsub_line_encoder #(
    parameter int RUN_B3ZS = 3,
    parameter int RUN_HDB3 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_b3,
    input  logic enc_off,
    input  logic all_ones,
    input  logic rloop,
    input  logic tx_pos,
    input  logic tx_neg,
    input  logic rx_pos,
    input  logic rx_neg,
    output logic line_pos,
    output logic line_neg
);
    logic [1:0] cap_tx, cap_rx, enc_sym, line;
    logic       din;

    zsub_capture cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_rails ({tx_pos, tx_neg}),
        .rx_rails ({rx_pos, rx_neg}),
        .cap_tx   (cap_tx),
        .cap_rx   (cap_rx),
        .din      (din)
    );

    zsub_subst #(.RUN_A(RUN_B3ZS), .RUN_B(RUN_HDB3)) sub_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_b3 (mode_b3),
        .din     (din),
        .enc_sym (enc_sym)
    );

    zsub_outsel sel_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rloop    (rloop),
        .all_ones (all_ones),
        .enc_off  (enc_off),
        .cap_tx   (cap_tx),
        .cap_rx   (cap_rx),
        .enc_sym  (enc_sym),
        .line     (line)
    );

    assign line_pos = line[1];
    assign line_neg = line[0];
endmodule

// File: rtl/zsub_line_encoder_chk.sv
module zsub_line_encoder_chk #(
    parameter int RUN_A = 3,
    parameter int RUN_B = 4
) (
    input logic clk,
    input logic rst_n,
    input logic mode_b3,
    input logic enc_off,
    input logic all_ones,
    input logic rloop,
    input logic tx_pos,
    input logic tx_neg,
    input logic rx_pos,
    input logic rx_neg,
    input logic line_pos,
    input logic line_neg
);
    logic       enc_mode, pulse;
    logic       prev_enc_q, armed_q;
    logic [2:0] run_q;
    int         lim;

    assign enc_mode = !enc_off && !rloop && !all_ones;
    assign pulse    = line_pos || line_neg;
    assign lim      = mode_b3 ? RUN_A : RUN_B;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_enc_q <= 1'b0;
            armed_q    <= 1'b0;
            run_q      <= '0;
        end else begin
            prev_enc_q <= enc_mode;
            if (!enc_mode || !prev_enc_q) armed_q <= 1'b0;
            else if (pulse)               armed_q <= 1'b1;
            if (pulse)                    run_q <= '0;
            else if (run_q != 3'd7)       run_q <= run_q + 3'd1;
        end
    end

    AST_ENC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        enc_mode |=> $onehot0({line_pos, line_neg})); // R3

    AST_ZERO_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (int'(run_q) < lim)); // R4

    AST_ALL_ONES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (all_ones && !rloop) |=> (line_pos != line_neg)); // R8

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_off && !all_ones && !rloop && $past(enc_off && !all_ones && !rloop)
         && $past(enc_off && !all_ones && !rloop, 2))
        |-> ({line_pos, line_neg} == $past({tx_pos, tx_neg}, 2))); // R7

    AST_RLOOP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rloop && $past(rloop) && $past(rloop, 2))
        |-> ({line_pos, line_neg} == $past({rx_pos, rx_neg}, 2))); // R9
endmodule

bind zsub_line_encoder zsub_line_encoder_chk #(.RUN_A(RUN_B3ZS), .RUN_B(RUN_HDB3)) chk_i (.*);

// File: tb/zsub_line_encoder_tb_top.sv
module zsub_line_encoder_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst_n = 1'b0;
    logic mode_b3 = 1'b1, enc_off = 1'b0, all_ones = 1'b0, rloop = 1'b0;
    logic tx_pos = 1'b0, tx_neg = 1'b0, rx_pos = 1'b0, rx_neg = 1'b0;
    logic line_pos, line_neg;

    int checks = 0;
    int errors = 0;
    int k = 0;
    int lat = 2;
    bit chk_en = 1'b0;
    logic [1:0] expq[$];
    logic [1:0] e_mon;
    bit   db_p[256];
    bit   db_n[256];
    int   zrun, maxrun;
    bit   armed_tb;
    string cur_tag = "";

    zsub_line_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .mode_b3(mode_b3), .enc_off(enc_off),
        .all_ones(all_ones), .rloop(rloop), .tx_pos(tx_pos), .tx_neg(tx_neg),
        .rx_pos(rx_pos), .rx_neg(rx_neg), .line_pos(line_pos), .line_neg(line_neg)
    );

    task automatic check(input logic [1:0] act, input logic [1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Rising-edge counter since reset release
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    // Monitor: pop and compare away from the rising edge
    always @(negedge clk) begin
        if (rst_n && chk_en && k >= lat && expq.size() > 0) begin
            e_mon = expq.pop_front();
            check({line_pos, line_neg}, e_mon, cur_tag);
            if (line_pos || line_neg) begin
                armed_tb = 1'b1;
                zrun = 0;
            end else if (armed_tb) begin
                zrun++;
                if (zrun > maxrun) maxrun = zrun;
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        tx_pos = 1'b0; tx_neg = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({line_pos, line_neg}, 2'b00, "R10 outputs low in reset");
        @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Sequential reference encoder
    task automatic ref_encode(input int run, input int m);
        bit lastpos = 1'b0;
        bit par = 1'b0;
        int i = 0;
        while (i < m) begin
            bit allz = 1'b1;
            if (i + run > m) allz = 1'b0;
            else for (int j = 0; j < run; j++) if (db_p[i+j] || db_n[i+j]) allz = 1'b0;
            if (allz) begin
                if (par) begin
                    for (int j = 0; j < run - 1; j++) expq.push_back(2'b00);
                    expq.push_back(lastpos ? 2'b10 : 2'b01);
                end else begin
                    lastpos = !lastpos;
                    expq.push_back(lastpos ? 2'b10 : 2'b01);
                    for (int j = 0; j < run - 2; j++) expq.push_back(2'b00);
                    expq.push_back(lastpos ? 2'b10 : 2'b01);
                end
                par = 1'b0;
                i += run;
            end else if (db_p[i] || db_n[i]) begin
                lastpos = !lastpos;
                expq.push_back(lastpos ? 2'b10 : 2'b01);
                par = !par;
                i++;
            end else begin
                expq.push_back(2'b00);
                i++;
            end
        end
    endtask

    task automatic run_enc(input bit b3, input int m, input int onemod,
                           input bit neg_only, input string tag);
        int run = b3 ? 3 : 4;
        mode_b3 = b3; enc_off = 1'b0; all_ones = 1'b0; rloop = 1'b0;
        for (int i = 0; i < m; i++) begin
            bit one = ($urandom_range(0, onemod - 1) == 0) || (i >= m - 4);
            db_n[i] = one;
            db_p[i] = neg_only ? 1'b0 : one;
        end
        expq.delete();
        ref_encode(run, m);
        lat = run + 2;
        maxrun = 0; zrun = 0; armed_tb = 1'b0; cur_tag = tag;
        do_reset();
        chk_en = 1'b1;
        for (int i = 0; i < m; i++) begin
            tx_pos = db_p[i]; tx_neg = db_n[i];
            @(posedge clk); #1;
        end
        tx_pos = 1'b1; tx_neg = 1'b1;
        repeat (lat + 2) @(posedge clk);
        #1;
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL R6 %s leftover actual=%0d expected=0", tag, expq.size());
        end
        checks++;
        if (maxrun >= run) begin
            errors++;
            $display("FAIL R4 zero run actual=%0d expected<%0d", maxrun, run);
        end
        chk_en = 1'b0;
    endtask

    task automatic run_pass(input bit loop, input int m, input string tag);
        mode_b3 = 1'b1;
        enc_off = !loop; rloop = loop; all_ones = loop;
        expq.delete();
        lat = 2; cur_tag = tag;
        do_reset();
        chk_en = 1'b1;
        for (int i = 0; i < m; i++) begin
            tx_pos = 1'($urandom_range(0, 1)); tx_neg = 1'($urandom_range(0, 1));
            rx_pos = 1'($urandom_range(0, 1)); rx_neg = 1'($urandom_range(0, 1));
            expq.push_back(loop ? {rx_pos, rx_neg} : {tx_pos, tx_neg});
            @(posedge clk); #1;
        end
        repeat (4) @(posedge clk);
        #1;
        checks++;
        if (expq.size() != 0) begin
            errors++;
            $display("FAIL %s leftover actual=%0d expected=0", tag, expq.size());
        end
        chk_en = 1'b0;
        rloop = 1'b0; all_ones = 1'b0; enc_off = 1'b0;
    endtask

    task automatic run_all_ones(input int m);
        mode_b3 = 1'b0; enc_off = 1'b1; all_ones = 1'b1; rloop = 1'b0;
        do_reset();
        for (int kk = 1; kk <= m; kk++) begin
            @(posedge clk); #1;
            tx_pos = 1'($urandom_range(0, 1)); tx_neg = 1'($urandom_range(0, 1));
            @(negedge clk);
            check({line_pos, line_neg}, (kk % 2 == 1) ? 2'b10 : 2'b01, "R8 all-ones train");
        end
        all_ones = 1'b0; enc_off = 1'b0;
    endtask

    initial begin
        void'($urandom(7));
        run_enc(1'b1, 200, 3, 1'b0, "R1 R2 R3 R6 B3ZS dense");
        run_enc(1'b0, 200, 3, 1'b0, "R1 R2 R3 R6 HDB3 dense");
        run_enc(1'b1, 200, 8, 1'b0, "R2 R4 B3ZS sparse");
        run_enc(1'b0, 200, 8, 1'b0, "R2 R4 HDB3 sparse");
        run_enc(1'b0, 150, 4, 1'b1, "R5 HDB3 negative rail only");
        run_pass(1'b0, 60, "R7 bypass");
        run_pass(1'b1, 60, "R9 remote loop over all-ones");
        run_all_ones(40);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule